// File: doc/BRIEF.md
# Serial Command and Fault Readback Port

This block is the serial front end of a four-channel low-side driver. A host lowers chip select to open a frame. At that moment the block takes a snapshot of the fault vector from the fault logic and switches on its data-out driver. The most significant fault bit appears on data-out straight away. Command bits then shift in on rising serial-clock edges while the remaining fault bits shift out on falling edges. When chip select rises, the four bits left in the shift register become the new output-control word and data-out returns to high impedance.

All three serial pins are brought into the faster system clock through synchronisers, and their edges are detected in that domain. Frames may carry any number of bits. Bits beyond the fourth pass straight through to data-out after the fault bits, so several devices can share one chain, with four bits per device. A frame with fewer than four clocks leaves some fault bits in the committed control word, and this is intended behaviour.

Top module: `cmd_fault_port`

## Requirements
- R1: While rst_n is low, ctrl_out is 0, sdo_oe is 0 and the shift register is cleared.
- R2: A chip-select falling edge loads fault_in into the shift register, sets sdo_oe to 1 and puts fault_in[3] on sdo.
- R3: On each serial-clock rising edge inside a frame, the shift register moves one place towards its MSB and takes sdi into bit 0.
- R4: On each serial-clock falling edge inside a frame, sdo takes the current shift-register MSB. The fault bits therefore leave MSB first: fault[3] at frame start, then fault[2], fault[1] and fault[0] after the first, second and third falling edges.
- R5: A chip-select rising edge copies the shift register into ctrl_out and clears sdo_oe.
- R6: ctrl_out bit i equal to 1 commands channel i on, and 0 commands it off. In a four-bit frame the first bit sent lands in ctrl_out[3] and the last in ctrl_out[0].
- R7: A frame with k<4 clocks commits {fault[3-k:0] snapshot, the k bits sent}. For example, two clocks commit the two low fault bits in ctrl_out[3:2].
- R8: In a frame of more than four clocks, the bit sent n-th appears on sdo after falling edge n+3, and only the last four bits sent are committed.
- R9: The fault snapshot is taken only at the chip-select falling edge. Changes to fault_in during the frame do not alter the bits shifted out.
- R10: While chip select is high, serial-clock and sdi activity has no effect: ctrl_out holds its value and sdo_oe stays 0.
- R11: A chip-select edge and a serial-clock edge that reach the system-clock domain in the same cycle resolve in favour of chip select: the clock edge is dropped.
- R12: An edge on cs_n, sclk or sdi affects the outputs at the third rising system-clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low during a frame |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data in |
| fault_in | input | NCH | Live per-channel fault vector, 1 = fault |
| sdo | output | 1 | Serial data out (fault bits, then pass-through) |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means high impedance |
| ctrl_out | output | NCH | Committed on/off command per channel |

## Verification
Two pairs of events can reach the same system-clock cycle. The first pair is a chip-select rise with a serial-clock rise, which could commit a word shifted one place too far. The second pair is a chip-select fall with a serial-clock rise, which could shift a data bit into the fresh fault snapshot. The bench provokes both by changing the pins on the same system-clock cycle, so that identical synchroniser paths deliver the two edges together. It judges the result from the committed control word, which differs from the expected value whenever the clock edge is taken. A behavioural model driven from delayed pin samples is compared against every output on every clock.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
   // bit positions of the synchronised serial pins
   localparam int unsigned PIN_CS   = 0;
   localparam int unsigned PIN_SCLK = 1;
   localparam int unsigned PIN_SDI  = 2;
   localparam int unsigned PIN_CNT  = 3;
   // idle level of each pin: chip select high, clock and data low
   localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/cfp_sync.sv
module cfp_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfp_sync needs at least two stages");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= INIT;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= INIT;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfp_edges.sv
module cfp_edges #(
   parameter int unsigned W     = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/cfp_shifter.sv
module cfp_shifter #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_lvl,
   input  logic           load,
   input  logic           commit,
   input  logic           shift,
   input  logic           drive,
   input  logic           sdi_bit,
   input  logic [NCH-1:0] fault_in,
   output logic [NCH-1:0] sr_q,
   output logic           sdo,
   output logic           oe
);
   logic active;
   assign active = ~cs_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
         sdo  <= 1'b0;
         oe   <= 1'b0;
      end else if (load) begin
         sr_q <= fault_in;
         sdo  <= fault_in[NCH-1];
         oe   <= 1'b1;
      end else if (commit) begin
         sdo  <= 1'b0;
         oe   <= 1'b0;
      end else if (active) begin
         if (shift)      sr_q <= {sr_q[NCH-2:0], sdi_bit};
         else if (drive) sdo  <= sr_q[NCH-1];
      end
   end

   // R2
   load_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (oe && sdo == $past(fault_in[NCH-1])));
   // R3
   shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && shift && !load) |=> (sr_q[0] == $past(sdi_bit)));
   // R4
   sdo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && drive && !load) |=> (sdo == $past(sr_q[NCH-1])));
endmodule

// File: rtl/cmd_fault_port.sv
module cmd_fault_port #(
   parameter int unsigned NCH         = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           sclk,
   input  logic           sdi,
   input  logic [NCH-1:0] fault_in,
   output logic           sdo,
   output logic           sdo_oe,
   output logic [NCH-1:0] ctrl_out
);
   import cfp_pkg::*;

   if (NCH < 2) begin : g_bad_nch
      $error("cmd_fault_port needs at least two channels");
   end

   localparam int unsigned EDGE_W = 2;

   logic [PIN_CNT-1:0] pins_raw, pins_s;
   logic [EDGE_W-1:0]  rise, fall;
   logic [NCH-1:0]     sr_q;
   logic               cs_lvl, cs_fall, cs_rise, ck_rise, ck_fall;

   assign pins_raw = {sdi, sclk, cs_n};

   cfp_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s));

   cfp_edges #(.W(EDGE_W), .INIT(PIN_IDLE[EDGE_W-1:0])) u_edges (
      .clk(clk), .rst_n(rst_n), .lvl(pins_s[EDGE_W-1:0]),
      .rise(rise), .fall(fall));

   assign cs_lvl  = pins_s[PIN_CS];
   assign cs_fall = fall[PIN_CS];
   assign cs_rise = rise[PIN_CS];
   assign ck_rise = rise[PIN_SCLK];
   assign ck_fall = fall[PIN_SCLK];

   cfp_shifter #(.NCH(NCH)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .load(cs_fall),
      .commit(cs_rise), .shift(ck_rise), .drive(ck_fall),
      .sdi_bit(pins_s[PIN_SDI]), .fault_in(fault_in),
      .sr_q(sr_q), .sdo(sdo), .oe(sdo_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_out <= '0;
      else if (cs_rise) ctrl_out <= sr_q;
   end

   // R5
   commit_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (!sdo_oe && ctrl_out == $past(sr_q)));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl && !cs_rise) |=> ($stable(ctrl_out) && !sdo_oe));
   // R11
   cs_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && ck_rise) |=> (sr_q == $past(fault_in)));
endmodule

// File: tb/cmd_fault_port_tb_top.sv
module cmd_fault_port_tb_top;
   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic [NCH-1:0] fault = '0;
   logic sdo, sdo_oe;
   logic [NCH-1:0] ctrl_out;

   int checks = 0;
   int errs = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cmd_fault_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .fault_in(fault), .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_out(ctrl_out));

   // behavioural model: pin history in a queue, acting on samples two clocks old
   logic [2:0] hist[$];
   logic [NCH-1:0] m_sr = '0, m_ctrl = '0;
   logic m_oe = 1'b0, m_sdo = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {};
         for (int i = 0; i < 4; i++) hist.push_back(3'b100);
         m_sr = '0; m_ctrl = '0; m_oe = 1'b0; m_sdo = 1'b0;
      end else begin
         logic [2:0] cur, prv;
         hist.push_back({cs_n, sclk, sdi});
         if (hist.size() > 8) void'(hist.pop_front());
         cur = hist[hist.size()-3];
         prv = hist[hist.size()-4];
         if (prv[2] && !cur[2]) begin
            m_sr = fault; m_oe = 1'b1; m_sdo = fault[NCH-1];
         end else if (!prv[2] && cur[2]) begin
            m_ctrl = m_sr; m_oe = 1'b0; m_sdo = 1'b0;
         end else if (!cur[2]) begin
            if (!prv[1] && cur[1])      m_sr = {m_sr[NCH-2:0], cur[0]};
            else if (prv[1] && !cur[1]) m_sdo = m_sr[NCH-1];
         end
      end
   end

   // R12: compare every output with the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (sdo_oe !== m_oe || ctrl_out !== m_ctrl || (m_oe && sdo !== m_sdo)) begin
            errs++;
            $display("FAIL R12 cycle: actual oe=%0d ctrl=%0h sdo=%0d expected oe=%0d ctrl=%0h sdo=%0d",
                     sdo_oe, ctrl_out, sdo, m_oe, m_ctrl, m_sdo);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic frame_open();
      @(negedge clk) cs_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic frame_close();
      @(negedge clk) cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, output logic so);
      @(negedge clk) sdi = b;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
      repeat (5) @(negedge clk);
      so = sdo;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errs++;
         $display("FAIL R12 watchdog: actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic so;
      logic [7:0] pat;
      repeat (3) @(negedge clk);
      check("R1 ctrl in reset", ctrl_out, 0);
      check("R1 oe in reset", sdo_oe, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // four-bit frame
      fault = 4'b1010;
      frame_open();
      check("R2 oe after cs fall", sdo_oe, 1);
      check("R2 fault msb on sdo", sdo, 1);
      send_bit(1'b1, so); check("R4 fault bit 2", so, 0);
      send_bit(1'b1, so); check("R4 fault bit 1", so, 1);
      send_bit(1'b0, so); check("R4 fault bit 0", so, 0);
      send_bit(1'b0, so);
      frame_close();
      check("R6 R3 first bit to channel 3", ctrl_out, 4'b1100);
      check("R5 oe after cs rise", sdo_oe, 0);

      // short frame of two clocks
      fault = 4'b0110;
      frame_open();
      send_bit(1'b1, so);
      send_bit(1'b0, so);
      frame_close();
      check("R7 fault residue committed", ctrl_out, 4'b1010);

      // eight-bit cascade frame
      fault = 4'b0011;
      pat = 8'b10010110;
      frame_open();
      check("R8 fault msb", sdo, 0);
      for (int i = 0; i < 8; i++) begin
         send_bit(pat[7-i], so);
         if (i < 3)      check("R8 fault bits out", so, fault[2-i]);
         else if (i < 7) check("R8 pass-through", so, pat[7-(i-3)]);
      end
      frame_close();
      check("R8 last four committed", ctrl_out, 4'b0110);

      // activity with chip select high
      for (int i = 0; i < 3; i++) send_bit(1'b1, so);
      check("R10 ctrl held", ctrl_out, 4'b0110);
      check("R10 oe low", sdo_oe, 0);

      // snapshot only at frame start
      fault = 4'b0001;
      frame_open();
      @(negedge clk) fault = 4'b1110;
      send_bit(1'b0, so); check("R9 snapshot bit 2", so, 0);
      send_bit(1'b0, so); check("R9 snapshot bit 1", so, 0);
      send_bit(1'b0, so); check("R9 snapshot bit 0", so, 1);
      send_bit(1'b0, so);
      frame_close();
      check("R9 commit", ctrl_out, 4'b0000);

      // chip-select rise together with a clock rise
      frame_open();
      send_bit(1'b1, so); send_bit(1'b0, so);
      send_bit(1'b1, so); send_bit(1'b1, so);
      @(negedge clk) begin sdi = 1'b0; sclk = 1'b1; cs_n = 1'b1; end
      repeat (6) @(negedge clk);
      check("R11 clock edge dropped at commit", ctrl_out, 4'b1011);
      @(negedge clk) sclk = 1'b0;
      repeat (6) @(negedge clk);
      check("R10 ctrl after idle clock", ctrl_out, 4'b1011);

      // chip-select fall together with a clock rise
      fault = 4'b0101;
      @(negedge clk) begin sdi = 1'b1; sclk = 1'b1; cs_n = 1'b0; end
      repeat (6) @(negedge clk);
      check("R11 fault msb", sdo, 0);
      @(negedge clk) sclk = 1'b0;
      repeat (6) @(negedge clk);
      send_bit(1'b0, so);
      send_bit(1'b0, so);
      frame_close();
      check("R11 clock edge dropped at snapshot", ctrl_out, 4'b0100);

      done = 1;
      summary();
      $finish;
   end
endmodule